// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block sits beside the data register of a NAND flash controller. While a page moves across that register, it builds a single-error-correcting Hamming code over the bytes. Each 256-byte chunk gets a 3-byte code of its own. A 512-byte page is therefore covered by two independent codes, 6 bytes in total. Host software uses the codes to find and flip one bad bit per chunk. The correction itself is not part of this block.

A 2-bit mode input drives the block. Reset mode clears the parity state and the byte counter. Accumulate mode folds each data-phase byte into the code of the current chunk. Off mode freezes everything. Read-out mode turns the shared read-data path away from flash data: each read strobe then steps through the stored code bytes in a fixed, permuted order.

The usual software sequence has two halves. Before a transfer it writes reset, then off, then accumulate. After the transfer it writes off, then read-out, reads the code bytes, and writes off again.

Top module: `nand_ecc_acc`

## Requirements
- R1: After reset, `rdata_o` follows `data_i`, and every code byte of a chunk that has received no data reads as 0xFF.
- R2: `mode_i` encodes 2'b00 off, 2'b01 accumulate, 2'b10 read-out and 2'b11 clear. A clock edge in clear mode zeroes all parity state and the byte counter, so every code byte reads 0xFF afterwards.
- R3: A byte is accumulated only on an edge where `mode_i` is accumulate, `data_valid_i` is 1, and both `cle_i` and `ale_i` are 0.
- R4: Code byte 0 holds the inverted line parities for index bits 3:0, and code byte 1 holds those for index bits 7:4. Here p(b) is the XOR of the 8 bits of a byte. For index bit k, the parity at code bit 2k (counting across the 16 bits of bytes 0 and 1) is the XOR of p(b) over the bytes whose chunk index has bit k equal to 0. Code bit 2k+1 is the same XOR over the bytes whose index has bit k equal to 1.
- R5: Code byte 2 is {~cp5, ~cp4, ~cp3, ~cp2, ~cp1, ~cp0, 1, 1}, where c is the XOR of all bytes in the chunk and:
  - cp0 = c0^c2^c4^c6
  - cp1 = c1^c3^c5^c7
  - cp2 = c0^c1^c4^c5
  - cp3 = c2^c3^c6^c7
  - cp4 = ^c[3:0]
  - cp5 = ^c[7:4]
- R6: Accumulated bytes 0 to 255 after a clear go into chunk 0, and bytes 256 to 511 go into chunk 1. Each chunk's byte index is the byte's position within that chunk.
- R7: Once 512 bytes have been accumulated, further bytes are ignored until the next clear.
- R8: In read-out mode, `rdata_o` shows the next code byte. Each `rd_strobe_i` edge advances the pointer through this order: chunk 0 byte 1, byte 0, byte 2, then chunk 1 byte 1, byte 0, byte 2. After the last byte the order wraps back to the start.
- R9: Outside read-out mode, `rdata_o` equals `data_i`, and the read-out pointer returns to its first position.
- R10: In off mode, data bytes and strobes leave the stored codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | ECC mode: 00 off, 01 accumulate, 10 read-out, 11 clear |
| data_valid_i | input | 1 | A byte crosses the data register this cycle |
| cle_i | input | 1 | Command latch phase, excluded from accumulation |
| ale_i | input | 1 | Address latch phase, excluded from accumulation |
| rd_strobe_i | input | 1 | Data register read, advances the read-out pointer |
| data_i | input | 8 | Byte on the data register |
| rdata_o | output | 8 | Read data: a code byte in read-out mode, otherwise data_i |

## Verification
Incrementing, scrambled and all-zero data patterns are each accumulated across a full 512-byte page. A byte that differs in every index and bit position exposes a wrong line-parity or column-parity mapping. A page that is all zero except for one set bit checks that the line parities single out that byte's index and bit. Command and address cycles, idle cycles, off-mode bytes and bytes past the 512th are mixed in to separate qualified transfers from ignored ones. Partial read-outs that leave and re-enter read-out mode, plus reads past the sixth byte, tell apart the pointer's restart behaviour and its wrap.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    ECC_OFF  = 2'b00,
    ECC_ACC  = 2'b01,
    ECC_READ = 2'b10,
    ECC_CLR  = 2'b11
  } ecc_mode_e;

  localparam int CODE_W = 24;

  // column parities {cp5..cp0} from the XOR of all chunk bytes
  function automatic logic [5:0] col_par(input logic [7:0] c);
    col_par = {^c[7:4], ^c[3:0], c[2]^c[3]^c[6]^c[7], c[0]^c[1]^c[4]^c[5],
               c[1]^c[3]^c[5]^c[7], c[0]^c[2]^c[4]^c[6]};
  endfunction
endpackage

// File: rtl/nand_ecc_chunk.sv
module nand_ecc_chunk
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [7:0]          byte_i,
  output logic [CODE_W-1:0]   code_o
);
  localparam int LP_W = 2 * IDX_W;

  logic [LP_W-1:0] lp_q, lp_d;
  logic [7:0]      col_q;
  logic            bpar;

  assign bpar = ^byte_i;

  for (genvar k = 0; k < IDX_W; k++) begin : g_lp
    assign lp_d[2*k]   = lp_q[2*k]   ^ (bpar & ~idx_i[k]);
    assign lp_d[2*k+1] = lp_q[2*k+1] ^ (bpar &  idx_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (clr_i) begin
      lp_q  <= '0;
      col_q <= '0;
    end else if (en_i) begin
      lp_q  <= lp_d;
      col_q <= col_q ^ byte_i;
    end
  end

  assign code_o = {~col_par(col_q), 2'b11, ~lp_q[15:8], ~lp_q[7:0]};
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         active_i,
  input  logic                         step_i,
  input  logic [NUM_CHUNKS*CODE_W-1:0] codes_i,
  output logic [7:0]                   byte_o
);
  localparam int CH_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

  logic [1:0]        slot_q;
  logic [CH_W-1:0]   chunk_q;
  logic [CODE_W-1:0] sel_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      chunk_q <= '0;
    end else if (!active_i) begin
      slot_q  <= '0;
      chunk_q <= '0;
    end else if (step_i) begin
      if (slot_q == 2'd2) begin
        slot_q  <= '0;
        chunk_q <= (chunk_q == CH_W'(NUM_CHUNKS - 1)) ? '0 : chunk_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_comb begin
    sel_code = '0;
    for (int c = 0; c < NUM_CHUNKS; c++)
      if (chunk_q == CH_W'(c)) sel_code = codes_i[c*CODE_W +: CODE_W];
  end

  // byte order per chunk: 1, 0, 2
  always_comb begin
    unique case (slot_q)
      2'd0:    byte_o = sel_code[15:8];
      2'd1:    byte_o = sel_code[7:0];
      default: byte_o = sel_code[23:16];
    endcase
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       data_valid_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       rd_strobe_i,
  input  logic [7:0] data_i,
  output logic [7:0] rdata_o
);
  localparam int IDX_W       = 8;
  localparam int CHUNK_BYTES = 1 << IDX_W;
  localparam int TOTAL       = CHUNK_BYTES * NUM_CHUNKS;
  localparam int CNT_W       = $clog2(TOTAL + 1);
  localparam int CH_W        = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

  ecc_mode_e                    mode;
  logic [CNT_W-1:0]             byte_cnt_q;
  logic                         take, clr;
  logic [CH_W-1:0]              cur_chunk;
  logic [NUM_CHUNKS*CODE_W-1:0] code_flat;
  logic [7:0]                   ecc_byte;

  assign mode = ecc_mode_e'(mode_i);
  assign clr  = (mode == ECC_CLR);
  assign take = (mode == ECC_ACC) && data_valid_i && !cle_i && !ale_i &&
                (byte_cnt_q != CNT_W'(TOTAL));
  assign cur_chunk = CH_W'(byte_cnt_q >> IDX_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   byte_cnt_q <= '0;
    else if (clr)  byte_cnt_q <= '0;
    else if (take) byte_cnt_q <= byte_cnt_q + 1'b1;
  end

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    nand_ecc_chunk #(.IDX_W(IDX_W)) u_chunk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (take && (cur_chunk == CH_W'(c))),
      .idx_i  (byte_cnt_q[IDX_W-1:0]),
      .byte_i (data_i),
      .code_o (code_flat[c*CODE_W +: CODE_W])
    );
  end

  nand_ecc_readout #(.NUM_CHUNKS(NUM_CHUNKS)) u_readout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (mode == ECC_READ),
    .step_i   (rd_strobe_i),
    .codes_i  (code_flat),
    .byte_o   (ecc_byte)
  );

  assign rdata_o = (mode == ECC_READ) ? ecc_byte : data_i;
endmodule

// File: rtl/nand_ecc_acc_chk.sv
module nand_ecc_acc_chk #(
  parameter int NUM_CHUNKS = 2,
  parameter int CNT_W      = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [1:0]                 mode_i,
  input logic                       cle_i,
  input logic                       ale_i,
  input logic [7:0]                 data_i,
  input logic [7:0]                 rdata_o,
  input logic [NUM_CHUNKS*24-1:0]   codes,
  input logic [CNT_W-1:0]           byte_cnt
);
  localparam int TOTAL = 256 * NUM_CHUNKS;

  a_r2_clear_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> (codes == {NUM_CHUNKS{24'hFFFFFF}}));

  a_r3_ctrl_phase_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cle_i || ale_i) && mode_i != 2'b11) |=> $stable(codes));

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(byte_cnt) <= TOTAL));

  a_r7_full_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(byte_cnt) == TOTAL && mode_i != 2'b11) |=> $stable(codes));

  a_r9_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b10) |-> (rdata_o == data_i));

  a_r10_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> ($stable(codes) && $stable(byte_cnt)));
endmodule

bind nand_ecc_acc nand_ecc_acc_chk #(.NUM_CHUNKS(NUM_CHUNKS), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .cle_i    (cle_i),
  .ale_i    (ale_i),
  .data_i   (data_i),
  .rdata_o  (rdata_o),
  .codes    (code_flat),
  .byte_cnt (byte_cnt_q)
);

// File: tb/nand_ecc_acc_test.sv
module nand_ecc_acc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       dv = 1'b0, cle = 1'b0, ale = 1'b0, rds = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] rdata;

  int checks = 0, errors = 0;
  bit running = 0;
  string cur_tag = "R1";

  // reference model state
  logic [7:0] mem [512];
  int m_cnt = 0, m_slot = 0, m_chunk = 0;

  always #10 clk = ~clk;

  nand_ecc_acc uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .data_valid_i(dv),
    .cle_i(cle), .ale_i(ale), .rd_strobe_i(rds), .data_i(din), .rdata_o(rdata)
  );

  function automatic logic [23:0] ref_code(input int c);
    logic [15:0] lp = '0;
    logic [7:0]  col = '0;
    logic [5:0]  cp;
    int hi = (m_cnt < (c + 1) * 256) ? m_cnt : (c + 1) * 256;
    for (int i = c * 256; i < hi; i++) begin
      logic p = ^mem[i];
      int idx = i - c * 256;
      col ^= mem[i];
      for (int k = 0; k < 8; k++)
        if ((idx >> k) & 1) lp[2*k+1] ^= p; else lp[2*k] ^= p;
    end
    cp[0] = col[0] ^ col[2] ^ col[4] ^ col[6];
    cp[1] = col[1] ^ col[3] ^ col[5] ^ col[7];
    cp[2] = col[0] ^ col[1] ^ col[4] ^ col[5];
    cp[3] = col[2] ^ col[3] ^ col[6] ^ col[7];
    cp[4] = ^col[3:0];
    cp[5] = ^col[7:4];
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction

  function automatic logic [7:0] exp_rdata();
    logic [23:0] cd;
    if (mode != 2'b10) return din;
    cd = ref_code(m_chunk);
    case (m_slot)
      0: return cd[15:8];
      1: return cd[7:0];
      default: return cd[23:16];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_slot = 0; m_chunk = 0;
    end else begin
      if (mode == 2'b11) m_cnt = 0;
      else if (mode == 2'b01 && dv && !cle && !ale && m_cnt < 512) begin
        mem[m_cnt] = din;
        m_cnt++;
      end
      if (mode != 2'b10) begin m_slot = 0; m_chunk = 0; end
      else if (rds) begin
        if (m_slot == 2) begin m_slot = 0; m_chunk = (m_chunk + 1) % 2; end
        else m_slot++;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk)
    if (running && rst_n) chk(cur_tag, rdata, exp_rdata());

  task automatic step(); @(posedge clk); #2; endtask

  task automatic set_mode(input logic [1:0] m); mode = m; step(); endtask

  task automatic put(input logic [7:0] b, input logic c = 0, input logic a = 0);
    din = b; dv = 1'b1; cle = c; ale = a; step();
    dv = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin rds = 1'b1; step(); end
    rds = 1'b0;
  endtask

  task automatic enable_acc();
    set_mode(2'b11); set_mode(2'b00); set_mode(2'b01);
  endtask

  task automatic readout(input int n);
    set_mode(2'b00); set_mode(2'b10); rd(n); set_mode(2'b00);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1", rdata, din);
    rst_n = 1'b1;
    step();
    running = 1;
    cur_tag = "R1";
    din = 8'h3C; step();
    chk("R1", rdata, 8'h3C);
    mode = 2'b10; step();
    for (int i = 0; i < 6; i++) begin
      #8 chk("R1", rdata, 8'hFF);
      rds = 1'b1; step(); rds = 1'b0;
    end
    set_mode(2'b00);

    // chunk 0: incrementing data with control-phase and idle cycles
    cur_tag = "R4";
    enable_acc();
    for (int i = 0; i < 256; i++) begin
      if (i % 37 == 5) begin cur_tag = "R3"; put(8'hA5, 1, 0); put(8'h5A, 0, 1); step(); cur_tag = "R4"; end
      put(8'(i));
    end
    cur_tag = "R5";
    readout(3);

    // off mode leaves state untouched
    cur_tag = "R10";
    set_mode(2'b00);
    for (int i = 0; i < 8; i++) put(8'hF0 ^ 8'(i));
    rds = 1'b1; step(); rds = 1'b0;
    readout(3);

    // chunk 1 continues the count
    cur_tag = "R6";
    set_mode(2'b01);
    for (int i = 0; i < 256; i++) put(8'((i * 7 + 3) ^ 8'h5A));
    cur_tag = "R8";
    readout(8);

    // partial read-out then restart
    cur_tag = "R9";
    set_mode(2'b10); rd(2); set_mode(2'b00); din = 8'h77; step();
    set_mode(2'b10); rd(4); set_mode(2'b00);

    // bytes past 512 ignored
    cur_tag = "R7";
    set_mode(2'b01);
    for (int i = 0; i < 10; i++) put(8'hC3 + 8'(i));
    readout(6);

    // clear then single set bit in chunk 1
    cur_tag = "R2";
    set_mode(2'b11);
    readout(6);
    cur_tag = "R4";
    enable_acc();
    for (int i = 0; i < 512; i++) put((i == 256 + 173) ? 8'h20 : 8'h00);
    cur_tag = "R5";
    readout(6);

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule